// File: doc/BRIEF.md
# Random Test Socket Self-Test Wrapper

This block wraps a small circuit under test (CUT) that has parallel primary inputs, parallel primary outputs and one internal scan path. In functional mode it is transparent: the functional input word reaches the CUT unchanged. When a test is started, a controller switches the CUT inputs over to a parallel pseudo-random pattern source and the scan-in pin over to a serial pseudo-random bit source. It then steps the CUT for a fixed number of rounds.

In every round the CUT's primary outputs are folded into a parallel-input signature register. The CUT's scan-out bit is folded into a serial-input signature register. After the last round, the controller compares both signatures with golden values supplied at its ports. It then raises `done`, together with `pass` when both values match. The CUT itself lives outside the wrapper and is attached through the `cut_*` ports; it advances only while `cut_step` is high.

All four shift registers use the same shift-left recurrence: `next = {s[W-2:0], ^(s & TAPS)}`. The tap masks default to maximal-length polynomials chosen from the register width.

Top module: `rts_bist_wrap`

## Requirements
- R1: While `rst_n` is low and after its release, `done` and `pass` are 0, `func_mode` is 1 and `cut_step` is 0.
- R2: While `func_mode` is 1, `cut_pi` equals `func_pi` and `cut_si` is 0.
- R3: When `start` is accepted, the next cycle is a single setup cycle with `func_mode` 0 and `cut_step` 0. It is followed by exactly ROUNDS cycles with `cut_step` 1. `cut_step` is never 1 while `func_mode` is 1.
- R4: In the first round `cut_pi` equals PRPG_SEED. Each later round presents `{p[PI_W-2:0], ^(p & PRPG_TAPS)}` of the previous round's vector `p`.
- R5: `cut_si` carries the most significant bit of a serial LFSR. That LFSR is loaded with SRSG_SEED in the setup cycle and follows the same recurrence with SRSG_TAPS once per round.
- R6: `misr_sig` is cleared in the setup cycle. Each round it becomes `{m[PO_W-2:0], ^(m & MISR_TAPS)} ^ cut_po`.
- R7: `sisa_sig` is cleared in the setup cycle. Each round it becomes `{s[SISA_W-2:0], ^(s & SISA_TAPS) ^ cut_so}`.
- R8: After the last round there is one compare cycle with `done` still 0. After it, `done` is 1, `func_mode` is 1, and `pass` is 1 exactly when `misr_sig` equals `golden_misr` and `sisa_sig` equals `golden_sisa`. `pass` is never 1 without `done`.
- R9: With the default tap masks, the pattern vector does not return to its seed within 2^PI_W - 1 rounds.
- R10: `start` is ignored from the setup cycle through the compare cycle. The round count, the signatures and the verdict are unaffected.
- R11: A `start` accepted while `done` is 1 clears `done` and `pass` in the setup cycle and reruns the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a self-test run (taken only when idle or done) |
| golden_misr | input | PO_W | Expected parallel signature |
| golden_sisa | input | SISA_W | Expected serial signature |
| func_pi | input | PI_W | Functional input word for the CUT |
| cut_pi | output | PI_W | Word driven to the CUT primary inputs |
| cut_po | input | PO_W | CUT primary outputs |
| cut_si | output | 1 | CUT scan-in bit |
| cut_so | input | 1 | CUT scan-out bit |
| cut_step | output | 1 | CUT advance enable, one pulse per round |
| func_mode | output | 1 | 1 functional, 0 under test |
| done | output | 1 | Test finished |
| pass | output | 1 | Both signatures matched (valid with done) |
| misr_sig | output | PO_W | Current parallel signature |
| sisa_sig | output | SISA_W | Current serial signature |

## Verification
The bench builds the wrapper with an 8-bit pattern source, an 8-bit output path, a 5-bit serial source, an 8-bit serial analyzer and ROUNDS = 255, which is the full period of the 8-bit source. That length lets a single run show that the seed never recurs. It also lets the 5-bit scan source wrap several times, so both signatures pass through many states. The bench attaches a small CUT model whose scan chain keeps its state from run to run. Because of that, the expected signatures differ between back-to-back runs. Golden values are corrupted one bit at a time to reach the failing verdict through each of the two signatures.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RUN   = 3'd2,
    ST_CMP   = 3'd3,
    ST_DONE  = 3'd4
  } bist_state_e;

  function automatic logic [31:0] width_mask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // Maximal-length shift-left feedback masks (bit n-1 set for tap n).
  function automatic logic [31:0] default_taps(input int w);
    case (w)
      2:  return 32'h0000_0003;
      3:  return 32'h0000_0006;
      4:  return 32'h0000_000C;
      5:  return 32'h0000_0014;
      6:  return 32'h0000_0030;
      7:  return 32'h0000_0060;
      8:  return 32'h0000_00B8;
      9:  return 32'h0000_0110;
      10: return 32'h0000_0240;
      11: return 32'h0000_0500;
      12: return 32'h0000_0829;
      13: return 32'h0000_100D;
      14: return 32'h0000_2015;
      15: return 32'h0000_6000;
      16: return 32'h0000_D008;
      32: return 32'h8020_0003;
      default: return (32'd3 << (w - 2)) & width_mask(w);
    endcase
  endfunction

  function automatic logic [31:0] lfsr_step(input logic [31:0] s,
                                            input logic [31:0] taps,
                                            input int w);
    logic fb;
    fb = ^(s & taps & width_mask(w));
    return ((s << 1) | {31'd0, fb}) & width_mask(w);
  endfunction

  function automatic logic [31:0] misr_step(input logic [31:0] s,
                                            input logic [31:0] taps,
                                            input logic [31:0] d,
                                            input int w);
    return lfsr_step(s, taps, w) ^ (d & width_mask(w));
  endfunction

  function automatic logic [31:0] sisa_step(input logic [31:0] s,
                                            input logic [31:0] taps,
                                            input logic b,
                                            input int w);
    return lfsr_step(s, taps, w) ^ {31'd0, b};
  endfunction

endpackage

// File: rtl/bist_lfsr_src.sv
module bist_lfsr_src
  import bist_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned OUT_W = 8,
  parameter logic [W-1:0] TAPS = W'(default_taps(W)),
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [OUT_W-1:0] out
);

  logic [W-1:0]  state_q;
  logic [31:0]   nxt_wide;
  logic [W-1:0]  state_nxt;

  always_comb begin
    nxt_wide  = lfsr_step(32'(state_q), 32'(TAPS), W);
    state_nxt = nxt_wide[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (load)    state_q <= SEED;
    else if (step)    state_q <= state_nxt;
  end

  // Serial variant taps the top bits only; parallel variant uses all of them.
  assign out = state_q[W-1 -: OUT_W];

endmodule

// File: rtl/bist_sig_reg.sv
module bist_sig_reg
  import bist_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] TAPS = W'(default_taps(W))
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);

  logic [W-1:0] sig_q;
  logic [31:0]  nxt_wide;
  logic [W-1:0] sig_nxt;

  always_comb begin
    nxt_wide = misr_step(32'(sig_q), 32'(TAPS), 32'(din), W);
    sig_nxt  = nxt_wide[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig_q <= '0;
    else if (clear) sig_q <= '0;
    else if (step)  sig_q <= sig_nxt;
  end

  assign sig = sig_q;

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int unsigned ROUNDS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sig_match,
  output logic load,
  output logic step,
  output logic func_mode,
  output logic round_last,
  output logic start_taken,
  output logic done,
  output logic pass
);

  localparam int unsigned CNT_W = (ROUNDS < 2) ? 1 : $clog2(ROUNDS);

  bist_state_e       state_q, state_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, pass_q;

  assign func_mode   = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign load        = (state_q == ST_SETUP);
  assign step        = (state_q == ST_RUN);
  assign start_taken = start && func_mode;
  assign round_last  = step && (cnt_q == CNT_W'(ROUNDS - 1));

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (start) state_nxt = ST_SETUP;
      ST_SETUP:         state_nxt = ST_RUN;
      ST_RUN:           if (round_last) state_nxt = ST_CMP;
      ST_CMP:           state_nxt = ST_DONE;
      default:          state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (load)      cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
      if (start_taken) begin
        done_q <= 1'b0;
        pass_q <= 1'b0;
      end else if (state_q == ST_CMP) begin
        done_q <= 1'b1;
        pass_q <= sig_match;
      end
    end
  end

  assign done = done_q;
  assign pass = pass_q;

endmodule

// File: rtl/rts_bist_wrap.sv
module rts_bist_wrap
  import bist_pkg::*;
#(
  parameter int unsigned PI_W   = 8,
  parameter int unsigned PO_W   = 8,
  parameter int unsigned SRSG_W = 5,
  parameter int unsigned SISA_W = 8,
  parameter int unsigned ROUNDS = 64,
  parameter logic [PI_W-1:0]   PRPG_TAPS = PI_W'(default_taps(PI_W)),
  parameter logic [SRSG_W-1:0] SRSG_TAPS = SRSG_W'(default_taps(SRSG_W)),
  parameter logic [PO_W-1:0]   MISR_TAPS = PO_W'(default_taps(PO_W)),
  parameter logic [SISA_W-1:0] SISA_TAPS = SISA_W'(default_taps(SISA_W)),
  parameter logic [PI_W-1:0]   PRPG_SEED = PI_W'(1),
  parameter logic [SRSG_W-1:0] SRSG_SEED = SRSG_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PO_W-1:0]   golden_misr,
  input  logic [SISA_W-1:0] golden_sisa,
  input  logic [PI_W-1:0]   func_pi,
  output logic [PI_W-1:0]   cut_pi,
  input  logic [PO_W-1:0]   cut_po,
  output logic              cut_si,
  input  logic              cut_so,
  output logic              cut_step,
  output logic              func_mode,
  output logic              done,
  output logic              pass,
  output logic [PO_W-1:0]   misr_sig,
  output logic [SISA_W-1:0] sisa_sig
);

  // Named internal events (observed by the bound checker).
  logic load, step, round_last, start_taken, sig_match;
  logic [PI_W-1:0] prpg_vec;
  logic [0:0]      srsg_bit;

  bist_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sig_match(sig_match),
    .load(load), .step(step), .func_mode(func_mode),
    .round_last(round_last), .start_taken(start_taken),
    .done(done), .pass(pass)
  );

  bist_lfsr_src #(.W(PI_W), .OUT_W(PI_W), .TAPS(PRPG_TAPS), .SEED(PRPG_SEED)) u_prpg (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .out(prpg_vec)
  );

  bist_lfsr_src #(.W(SRSG_W), .OUT_W(1), .TAPS(SRSG_TAPS), .SEED(SRSG_SEED)) u_srsg (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .out(srsg_bit)
  );

  bist_sig_reg #(.W(PO_W), .TAPS(MISR_TAPS)) u_misr (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
    .din(cut_po), .sig(misr_sig)
  );

  // Serial analyzer: a signature register fed only at bit 0.
  bist_sig_reg #(.W(SISA_W), .TAPS(SISA_TAPS)) u_sisa (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
    .din(SISA_W'(cut_so)), .sig(sisa_sig)
  );

  assign sig_match = (misr_sig == golden_misr) && (sisa_sig == golden_sisa);
  assign cut_pi    = func_mode ? func_pi : prpg_vec;
  assign cut_si    = !func_mode && srsg_bit[0];
  assign cut_step  = step;

endmodule

// File: rtl/rts_bist_wrap_chk.sv
module rts_bist_wrap_chk
  import bist_pkg::*;
#(
  parameter int unsigned PI_W   = 8,
  parameter int unsigned PO_W   = 8,
  parameter int unsigned SISA_W = 8,
  parameter logic [PI_W-1:0]   PRPG_TAPS = PI_W'(default_taps(PI_W)),
  parameter logic [PO_W-1:0]   MISR_TAPS = PO_W'(default_taps(PO_W)),
  parameter logic [SISA_W-1:0] SISA_TAPS = SISA_W'(default_taps(SISA_W))
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_taken,
  input logic              round_last,
  input logic              cut_step,
  input logic              func_mode,
  input logic [PI_W-1:0]   cut_pi,
  input logic [PO_W-1:0]   cut_po,
  input logic              cut_so,
  input logic              done,
  input logic              pass,
  input logic [PO_W-1:0]   misr_sig,
  input logic [SISA_W-1:0] sisa_sig
);

  p_step_in_test_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cut_step |-> !func_mode);

  p_last_round_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    round_last |=> !cut_step);

  p_prpg_sequence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_step && $past(cut_step)) |->
      (32'(cut_pi) == lfsr_step(32'($past(cut_pi)), 32'(PRPG_TAPS), PI_W)));

  p_misr_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cut_step |=>
      (32'(misr_sig) == misr_step(32'($past(misr_sig)), 32'(MISR_TAPS),
                                  32'($past(cut_po)), PO_W)));

  p_sisa_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cut_step |=>
      (32'(sisa_sig) == sisa_step(32'($past(sisa_sig)), 32'(SISA_TAPS),
                                  $past(cut_so), SISA_W)));

  p_pass_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  p_done_is_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> func_mode);

  p_start_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken |=> (!func_mode && !cut_step && !done));

endmodule

bind rts_bist_wrap rts_bist_wrap_chk #(
  .PI_W(PI_W), .PO_W(PO_W), .SISA_W(SISA_W),
  .PRPG_TAPS(PRPG_TAPS), .MISR_TAPS(MISR_TAPS), .SISA_TAPS(SISA_TAPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_taken(start_taken), .round_last(round_last),
  .cut_step(cut_step), .func_mode(func_mode), .cut_pi(cut_pi), .cut_po(cut_po),
  .cut_so(cut_so), .done(done), .pass(pass), .misr_sig(misr_sig), .sisa_sig(sisa_sig)
);

// File: tb/test_rts_bist_wrap.sv
`timescale 1ns/1ps

module cut_stub (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] pi,
  input  logic       si,
  output logic [7:0] po,
  output logic       so
);
  logic [5:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chain <= 6'd0;
    else if (step) chain <= {chain[4:0], si};
  end
  assign po = (pi ^ {pi[3:0], pi[7:4]}) + {2'b00, chain};
  assign so = chain[5];
endmodule

module test_rts_bist_wrap;

  localparam int ROUNDS = 255;
  localparam logic [7:0] PSEED = 8'hA5;
  localparam logic [4:0] SSEED = 5'h13;

  // Run table: {misr corruption, sisa corruption, expected pass, mid-run start}
  localparam logic [17:0] RUNS [4] = '{
    {8'h00, 8'h00, 1'b1, 1'b0},
    {8'h01, 8'h00, 1'b0, 1'b0},
    {8'h00, 8'h80, 1'b0, 1'b0},
    {8'h00, 8'h00, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] golden_misr = 8'h00;
  logic [7:0] golden_sisa = 8'h00;
  logic [7:0] func_pi = 8'h00;
  logic [7:0] cut_pi, cut_po, misr_sig, sisa_sig;
  logic cut_si, cut_so, cut_step, func_mode, done, pass;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] m_chain = 6'd0;

  always #2 clk = ~clk;

  rts_bist_wrap #(
    .PI_W(8), .PO_W(8), .SRSG_W(5), .SISA_W(8), .ROUNDS(ROUNDS),
    .PRPG_SEED(PSEED), .SRSG_SEED(SSEED)
  ) i_rts_bist_wrap (
    .clk(clk), .rst_n(rst_n), .start(start),
    .golden_misr(golden_misr), .golden_sisa(golden_sisa),
    .func_pi(func_pi), .cut_pi(cut_pi), .cut_po(cut_po),
    .cut_si(cut_si), .cut_so(cut_so), .cut_step(cut_step),
    .func_mode(func_mode), .done(done), .pass(pass),
    .misr_sig(misr_sig), .sisa_sig(sisa_sig)
  );

  cut_stub u_cut (
    .clk(clk), .rst_n(rst_n), .step(cut_step), .pi(cut_pi),
    .si(cut_si), .po(cut_po), .so(cut_so)
  );

  function automatic logic [7:0] nx8(input logic [7:0] s);
    logic fb = 1'b0;
    for (int i = 0; i < 8; i++) if (8'hB8 & (8'd1 << i)) fb = fb ^ s[i];
    return {s[6:0], fb};
  endfunction

  function automatic logic [4:0] nx5(input logic [4:0] s);
    return {s[3:0], s[4] ^ s[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_bist(input logic [7:0] mm, input logic [7:0] ms,
                          input bit exp_pass, input bit mid_start);
    logic [7:0] p = PSEED;
    logic [4:0] s = SSEED;
    logic [7:0] mi = 8'h00;
    logic [7:0] sa = 8'h00;
    logic [7:0] po;
    int seed_hits = 0;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    chk(!func_mode && !cut_step, "R3 setup cycle",
        {func_mode, cut_step}, 32'h0);
    chk(!done && !pass, "R11 done/pass cleared", {done, pass}, 32'h0);
    for (int k = 0; k < ROUNDS; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(cut_step && !func_mode, "R3 round step", {cut_step, func_mode}, 32'h2);
      chk(cut_pi == p, "R4 pattern", cut_pi, p);
      chk(cut_si == s[4], "R5 scan-in", cut_si, s[4]);
      if (k > 0 && cut_pi == PSEED) seed_hits++;
      po = (p ^ {p[3:0], p[7:4]}) + {2'b00, m_chain};
      mi = nx8(mi) ^ po;
      sa = nx8(sa) ^ {7'd0, m_chain[5]};
      m_chain = {m_chain[4:0], s[4]};
      p = nx8(p);
      s = nx5(s);
      start = (mid_start && k == 100);   // R10: request while busy
    end
    start = 1'b0;
    golden_misr = mi ^ mm;
    golden_sisa = sa ^ ms;
    @(posedge clk);
    @(negedge clk);
    chk(!done && !cut_step && !func_mode, "R8 compare cycle",
        {done, cut_step, func_mode}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk(done && func_mode, "R8 done and normal", {done, func_mode}, 32'h3);
    chk(pass == exp_pass, "R8 verdict", pass, exp_pass);
    chk(misr_sig == mi, "R6 parallel signature", misr_sig, mi);
    chk(sisa_sig == sa, "R7 serial signature", sisa_sig, sa);
    chk(seed_hits == 0, "R9 seed recurrence", seed_hits, 0);
    if (mid_start) chk(pass == 1'b1, "R10 start ignored while busy", pass, 1);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!done && !pass && func_mode && !cut_step, "R1 during reset",
        {done, pass, func_mode, cut_step}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !pass && func_mode && !cut_step, "R1 after reset",
        {done, pass, func_mode, cut_step}, 32'h2);

    // R2: transparent functional path before any test
    for (int k = 0; k < 6; k++) begin
      func_pi = 8'(k * 37 + 11);
      @(negedge clk);
      chk(cut_pi == func_pi && !cut_si, "R2 passthrough", cut_pi, func_pi);
    end

    // Main table: verdicts, signature corruption and busy start
    for (int r = 0; r < 4; r++) begin
      run_bist(RUNS[r][17:10], RUNS[r][9:2], RUNS[r][1], RUNS[r][0]);
      func_pi = 8'h3C ^ 8'(r);
      @(negedge clk);
      chk(cut_pi == func_pi && !cut_si, "R2 passthrough after done",
          cut_pi, func_pi);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule